// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 512K words by 16 bits with two byte lanes. The host hands over one request per access (address, write data, a byte-lane mask and a read/write flag) with a valid/ready handshake. The block then drives the memory's active-low select, write strobe, output-enable and per-lane enables, plus a data bus that is split into an output value, an input value and a driver-enable.

Every access runs through the same phases. First comes a set-up phase with all strobes inactive while the new address settles. Next is an access phase whose length is a cycle count derived from the nanosecond limits and the clock period. A recovery phase follows, in which every strobe is inactive again. The address register is loaded only at acceptance, so the address never moves while the memory is selected or a lane is enabled. During writes the output-enable stays inactive, and the data driver is held off in the first cycle of the write strobe, so the memory has released the bus before the controller drives it. Read data goes back to the host as a one-cycle valid pulse. A separate one-cycle completion pulse marks the end of each access.

Request handshake: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only in the idle state, so the host back-pressures itself by holding its request. The response has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must take when it appears.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, select, write strobe, output-enable and both lane enables are high, the data driver is off, `req_ready` is high and `rsp_valid` and `acc_done` are low.
- R2: A request is accepted only while `req_ready` is high. `req_ready` stays low from the accepting edge until the cycle in which `acc_done` pulses.
- R3: `mem_addr` changes only on an edge where, both before and after that edge, select, write strobe and both lane enables are high.
- R4: A read holds select and output-enable low and the write strobe high for the read access count. On the last edge of that phase the data is captured. `rsp_valid` pulses for one cycle, 2 + read count cycles after the accepting cycle. Lane 0 (bits 7:0) is selected by `req_be[0]` and lane 1 (bits 15:8) by `req_be[1]`. The data of a selected lane is returned and a lane that is not selected reads as zero.
- R5: A write holds select and write strobe low with output-enable high throughout, and pulls low only the lane enables whose `req_be` bit is 1. A lane that is not selected keeps its stored value.
- R6: The data driver is never on while output-enable is low. It is off in the first cycle of the write strobe. It is on for at least the data set-up count of cycles before the write strobe rises, and it is still on in the cycle after the rise.
- R7: Each count is the required time divided by the clock period, rounded up, with a minimum of 1. The read phase lasts the address-access count. The write phase lasts the larger of the pulse-width count and the data set-up count plus one.
- R8: `acc_done` pulses for one cycle at 2 + phase + recovery cycles after the accepting cycle. Recovery is the cycle-time count minus the phase length, with a minimum of 1.
- R9: Whenever `req_ready` is high, every memory strobe is inactive. Consecutive accesses are therefore separated by at least one fully idle cycle.
- R10: A write with `req_be` = 00 enables no lane and leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (19) | Word address |
| req_wdata | input | DW (16) | Write data |
| req_be | input | DW/8 (2) | Byte-lane mask, bit i selects bits 8i+7..8i |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DW (16) | Read data, unselected lanes zero |
| acc_done | output | 1 | One-cycle end-of-access pulse |
| mem_addr | output | AW (19) | Memory address |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DW/8 (2) | Lane enables, active low |
| mem_dq_out | output | DW (16) | Data toward memory |
| mem_dq_in | input | DW (16) | Data from memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The bench runs at a 5 ns clock, so every phase count is 2 or 3 cycles. That gives a read response 4 cycles after the accepting cycle, read completion at 5 and write completion at 6. These latencies are derived in the bench from the rounding rule. After each request the bench steps one falling edge at a time and records the index at which `rsp_valid` and `acc_done` first appear, then compares those indices with the derived values. A monitor also samples the strobes on every falling edge, counting select-low cycles and catching any address movement, driver-on-with-output-enable, or early or late driving around the write strobe.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_WRITE,
    ST_RECOV
  } asram_state_e;

  // whole clock cycles covering need_ps, never below one
  function automatic int cyc_of(input int need_ps, input int clk_ps);
    int c;
    c = (need_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt
);
  // counts cycles spent in the current phase, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart)      cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/asram_lane_ctl.sv
module asram_lane_ctl #(
  parameter int NL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [NL-1:0]   lane_sel,
  input  logic            capture,
  input  logic [8*NL-1:0] dq_in,
  output logic [NL-1:0]   be_n,
  output logic [8*NL-1:0] rdata
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign be_n[g] = !(active && lane_sel[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata[8*g +: 8] <= '0;
      else if (capture) rdata[8*g +: 8] <= lane_sel[g] ? dq_in[8*g +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 16,
  parameter int CLK_PS   = 10000,
  parameter int T_AA_PS  = 10000,
  parameter int T_RC_PS  = 10000,
  parameter int T_WP_PS  = 8000,
  parameter int T_WC_PS  = 10000,
  parameter int T_DS_PS  = 6000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            acc_done,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_ce_n,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic [DW/8-1:0] mem_be_n,
  output logic [DW-1:0]   mem_dq_out,
  input  logic [DW-1:0]   mem_dq_in,
  output logic            mem_dq_oe
);
  localparam int NL      = DW / 8;
  localparam int RD_CYC  = cyc_of(T_AA_PS, CLK_PS);
  localparam int WP_CYC  = cyc_of(T_WP_PS, CLK_PS);
  localparam int DS_CYC  = cyc_of(T_DS_PS, CLK_PS);
  localparam int WR_CYC  = imax(WP_CYC, DS_CYC + 1);
  localparam int RREC    = imax(1, cyc_of(T_RC_PS, CLK_PS) - RD_CYC);
  localparam int WREC    = imax(1, cyc_of(T_WC_PS, CLK_PS) - WR_CYC);
  localparam int MAXC    = imax(imax(RD_CYC, WR_CYC), imax(RREC, WREC));
  localparam int CW      = $clog2(MAXC + 1) + 1;
  localparam logic [CW-1:0] RD_LAST  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LAST  = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] RREC_LAST = CW'(RREC - 1);
  localparam logic [CW-1:0] WREC_LAST = CW'(WREC - 1);

  asram_state_e    state, state_n;
  logic [CW-1:0]   cnt;
  logic            wr_q;
  logic [NL-1:0]   be_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            rsp_q, done_q;
  logic            rd_end, wr_end, rec_end, accept, active;

  assign accept  = (state == ST_IDLE) && req_valid;
  assign rd_end  = (state == ST_READ)  && (cnt == RD_LAST);
  assign wr_end  = (state == ST_WRITE) && (cnt == WR_LAST);
  assign rec_end = (state == ST_RECOV) && (cnt == (wr_q ? WREC_LAST : RREC_LAST));
  assign active  = (state == ST_READ) || (state == ST_WRITE);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:  if (req_valid) state_n = ST_SETUP;
      ST_SETUP: state_n = wr_q ? ST_WRITE : ST_READ;
      ST_READ:  if (rd_end)  state_n = ST_RECOV;
      ST_WRITE: if (wr_end)  state_n = ST_RECOV;
      ST_RECOV: if (rec_end) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wr_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state  <= state_n;
      rsp_q  <= rd_end;
      done_q <= rec_end;
      if (accept) begin
        wr_q    <= req_write;
        be_q    <= req_be;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  asram_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_n != state),
    .cnt     (cnt)
  );

  asram_lane_ctl #(.NL(NL)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .lane_sel (be_q),
    .capture  (rd_end),
    .dq_in    (mem_dq_in),
    .be_n     (mem_be_n),
    .rdata    (rsp_rdata)
  );

  assign req_ready  = (state == ST_IDLE);
  assign rsp_valid  = rsp_q;
  assign acc_done   = done_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !active;
  assign mem_we_n   = (state != ST_WRITE);
  assign mem_oe_n   = (state != ST_READ);
  assign mem_dq_out = wdata_q;
  // driver waits one strobe cycle for bus release, holds one cycle past strobe end
  assign mem_dq_oe  = ((state == ST_WRITE) && (cnt != '0)) ||
                      ((state == ST_RECOV) && (cnt == '0) && wr_q);
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 19,
  parameter int NL = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          acc_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [NL-1:0] mem_be_n,
  input logic          mem_dq_oe
);
  logic quiet;
  assign quiet = mem_ce_n && mem_we_n && (&mem_be_n);

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> quiet && $past(quiet)); // R3
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R6
  AST_DRV_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe); // R6
  AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe); // R6
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n && !mem_ce_n); // R5
  AST_LANE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_be_n) |-> !mem_ce_n); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> quiet && mem_oe_n && !mem_dq_oe); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done); // R8
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .NL(NL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .acc_done  (acc_done),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  localparam int CLK_NS = 5;
  localparam int CLK_PS = CLK_NS * 1000;
  localparam int AW = 19;
  localparam int DW = 16;

  function automatic int ceil1(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  // expected counts per R7/R8
  localparam int E_RD   = ceil1(10000);
  localparam int E_DS   = ceil1(6000);
  localparam int E_WR   = (ceil1(8000) > E_DS + 1) ? ceil1(8000) : E_DS + 1;
  localparam int E_RREC = (ceil1(10000) - E_RD > 1) ? ceil1(10000) - E_RD : 1;
  localparam int E_WREC = (ceil1(10000) - E_WR > 1) ? ceil1(10000) - E_WR : 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid, acc_done;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0] mem_be_n;

  always #(CLK_NS / 2.0) clk = ~clk;

  asram_ctrl #(.AW(AW), .DW(DW), .CLK_PS(CLK_PS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .acc_done(acc_done),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int a);
    return 16'(a * 7) ^ 16'h5A5A;
  endfunction

  // memory model
  logic [15:0] mem_m [int];
  logic [15:0] shadow [int];
  function automatic logic [15:0] mget(input int a);
    return mem_m.exists(a) ? mem_m[a] : init_word(a);
  endfunction
  function automatic logic [15:0] sget(input int a);
    return shadow.exists(a) ? shadow[a] : init_word(a);
  endfunction

  always_comb begin
    logic [15:0] w;
    w = mget(int'(mem_addr));
    for (int i = 0; i < 2; i++)
      mem_dq_in[8*i +: 8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[i])
                            ? w[8*i +: 8] : 8'hA5;  // A5 stands in for a floating lane
  end

  always @(posedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] w;
      w = mget(int'(mem_addr));
      for (int i = 0; i < 2; i++)
        if (!mem_be_n[i]) w[8*i +: 8] = mem_dq_out[8*i +: 8];
      mem_m[int'(mem_addr)] = w;
    end
  end

  // strobe monitor
  bit mon_on = 0, cur_wr = 0;
  logic [1:0] cur_be = '0;
  int ce_low = 0, lane_bad = 0, viol_addr = 0, viol_drv = 0, viol_ctl = 0, viol_gap = 0;
  int drv_cnt = 0;
  logic [AW-1:0] prev_addr = '0;
  bit prev_quiet = 1, prev_we_n = 1;

  always @(negedge clk) begin
    if (mon_on) begin
      bit quiet;
      quiet = mem_ce_n && mem_we_n && (&mem_be_n);
      if (mem_addr != prev_addr && !(quiet && prev_quiet)) viol_addr++;
      if (!mem_ce_n) begin
        ce_low++;
        if (cur_wr && (!mem_oe_n || mem_we_n)) viol_ctl++;
        if (!cur_wr && (mem_oe_n || !mem_we_n)) viol_ctl++;
      end
      for (int i = 0; i < 2; i++) if (!mem_be_n[i] && !cur_be[i]) lane_bad++;
      if (mem_dq_oe && !mem_oe_n) viol_drv++;
      if (!mem_we_n) begin
        if (prev_we_n && mem_dq_oe) viol_drv++;
        if (mem_dq_oe) drv_cnt++;
      end else if (!prev_we_n) begin
        if (drv_cnt < E_DS || !mem_dq_oe) viol_drv++;
        drv_cnt = 0;
      end
      if (req_ready && !(quiet && mem_oe_n)) viol_gap++;
      prev_addr = mem_addr; prev_quiet = quiet; prev_we_n = mem_we_n;
    end
  end

  task automatic access(input bit wr, input int addr, input logic [15:0] data, input logic [1:0] be);
    int rk, dk;
    bit busy_bad;
    logic [15:0] got, expv, s;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(addr); req_wdata = data; req_be = be;
    cur_wr = wr; cur_be = be; ce_low = 0; lane_bad = 0;
    s = sget(addr);
    expv = 16'h0;
    for (int i = 0; i < 2; i++) begin
      if (wr && be[i]) s[8*i +: 8] = data[8*i +: 8];
      if (!wr && be[i]) expv[8*i +: 8] = s[8*i +: 8];
    end
    if (wr) shadow[addr] = s;
    rk = 0; dk = 0; busy_bad = 0; got = '0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 0;
      if (rsp_valid && rk == 0) begin rk = k; got = rsp_rdata; end
      if (acc_done) begin dk = k; break; end
      if (req_ready) busy_bad = 1;
    end
    check(!busy_bad, "R2 ready low while busy", int'(busy_bad), 0);
    if (wr) begin
      check(dk == E_WR + E_WREC + 2, "R8 write done latency", dk, E_WR + E_WREC + 2);
      check(rk == 0, "R4 no response on write", rk, 0);
      check(ce_low == E_WR, "R7 write phase length", ce_low, E_WR);
    end else begin
      check(dk == E_RD + E_RREC + 2, "R8 read done latency", dk, E_RD + E_RREC + 2);
      check(rk == E_RD + 2, "R4 read response latency", rk, E_RD + 2);
      check(got == expv, "R4 read data", int'(got), int'(expv));
      check(ce_low == E_RD, "R7 read phase length", ce_low, E_RD);
    end
    check(lane_bad == 0, be == 2'b00 ? "R10 no lane on empty mask" : "R5 lane enables follow mask",
          lane_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n), "R1 strobes high in reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'b11111);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    check(!mem_dq_oe && !rsp_valid && !acc_done, "R1 outputs idle",
          {mem_dq_oe, rsp_valid, acc_done}, 0);
    prev_addr = mem_addr;
    mon_on = 1;

    // directed corners
    access(1, 0, 16'hBEEF, 2'b11);
    access(0, 0, 16'h0, 2'b11);                 // R4 full word
    access(1, 'h7FFFF, 16'h1234, 2'b01);        // R5 lower lane only
    access(0, 'h7FFFF, 16'h0, 2'b11);
    access(1, 'h7FFFF, 16'hCD00, 2'b10);        // R5 upper lane only
    access(0, 'h7FFFF, 16'h0, 2'b11);
    access(0, 0, 16'h0, 2'b01);                 // R4 upper reads zero
    access(0, 0, 16'h0, 2'b10);                 // R4 lower reads zero
    access(1, 0, 16'h7777, 2'b00);              // R10 empty mask
    access(0, 0, 16'h0, 2'b11);
    access(0, 'h40000, 16'h0, 2'b11);           // never written

    // constrained random mix over a small address pool
    for (int n = 0; n < 80; n++) begin
      int a;
      int sel;
      sel = int'($urandom_range(0, 4));
      case (sel)
        0: a = 0;
        1: a = 'h7FFFF;
        2: a = 'h40000;
        default: a = int'($urandom_range(0, 15)) * 'h1111;
      endcase
      access(bit'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)));
    end

    @(negedge clk);
    check(viol_addr == 0, "R3 address moved with strobes active", viol_addr, 0);
    check(viol_drv == 0, "R6 data driver timing", viol_drv, 0);
    check(viol_ctl == 0, "R4 R5 strobe levels during access", viol_ctl, 0);
    check(viol_gap == 0, "R9 idle cycle strobes", viol_gap, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule